// File: doc/BRIEF.md
# I2C Register Target with Two-Byte Pointer

This block is an I2C bus target that gives a controller access to a register array of up to 65,536 byte-wide registers. The block runs on a fast system clock and treats the open-drain SCL and SDA lines as slow inputs. Both lines pass through two-flop synchronisers. Edge logic then recognises the START condition, the STOP condition and the rising and falling edges of SCL. A bit and byte state machine works on those events. It matches a fixed 7-bit device address, takes a register pointer as two bytes with the high byte first, and then writes or reads data bytes. The pointer steps by one after every data byte.

A write transaction is START, 0xC2, pointer high, pointer low, then any number of data bytes, then STOP. For a read, the controller sets the pointer in the same way, issues a repeated START and sends 0xC3. It then clocks bytes out until it declines to acknowledge one. The target drives SDA only through a drive-low enable and never holds SCL. The clock-to-bus ratio must therefore be at least 16 system clocks per bus bit.

The register side is a plain synchronous port with no back-pressure. `reg_we` acts as a one-cycle valid with no ready, and the array must accept every strobe. `reg_rdata` must show the contents of `reg_addr` within the same cycle, and the target samples it whenever it starts to send a byte.

Top module: `i2ct_target`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0x0000.
- R2: An address byte of 0xC2 (bits 7:1 = 0x61, bit 0 = 0 for write) or 0xC3 (bit 0 = 1 for read) is acknowledged. Any other address byte is not acknowledged. The target then acknowledges nothing and writes nothing until the next START or STOP.
- R3: The target changes `sda_oe` only while SCL is low. It samples SDA on the SCL high phase, one bit per clock pulse, MSB first, and a ninth clock follows each byte as the acknowledge slot.
- R4: A STOP (SDA rising while SCL high) returns the target to idle from any point, and `sda_oe` is released. A START (SDA falling while SCL high) restarts address reception at any point. Bytes already written are kept, and a partial byte cut off by STOP or START is neither written nor acknowledged.
- R5: After a matched write address, the first byte loads pointer bits 15:8 and the second loads bits 7:0. Both bytes are acknowledged. The pointer keeps its value across STOP and START.
- R6: Every later byte of a write is acknowledged and gives exactly one `reg_we` pulse of one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R7: The pointer increments by one after each written byte and wraps from 0xFFFF to 0x0000.
- R8: After a matched read address, the target sends bytes MSB first from the current pointer, and the pointer increments after each byte sent. It goes on while the controller acknowledges (SDA low in the ninth clock). After a byte that is not acknowledged, it releases SDA until the next START or STOP.
- R9: Each read byte is the value of `reg_rdata` while `reg_addr` holds that byte's pointer. A read from a fresh START with 0xC3 begins at the pointer left by earlier transfers.
- R10: Transfers work unchanged at about 100 kbit/s, 400 kbit/s and 1 Mbit/s bus rates with a 125 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | SDA drive-low enable (1 pulls the line low) |
| reg_addr | output | 16 | Register pointer, address for both write and read |
| reg_wdata | output | 8 | Byte to store, valid while `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe, no ready |
| reg_rdata | input | 8 | Contents of the register at `reg_addr`, same cycle |

## Verification
When a data byte of a write completes, one SCL falling edge has two effects in the same clock cycle. It asserts the acknowledge drive, and it issues the register strobe, with the pointer step following one cycle later. The bench drives bursts and single-byte writes. It then judges both effects together: the acknowledge seen on the wired SDA line, and the address and data logged by the register model. In one case a repeated START with the read address comes right after a written byte. The byte read back must come from the already-stepped pointer, which shows that the strobe used the old pointer and the step was not lost.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } i2ct_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR_HI,
    K_PTR_LO,
    K_DATA
  } i2ct_kind_e;
endpackage

// File: rtl/i2ct_sync.sv
`timescale 1ns/1ps
module i2ct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2ct_cond.sv
`timescale 1ns/1ps
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_hi   = scl_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_fsm.sv
`timescale 1ns/1ps
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h61,
  parameter int         DW       = 8,
  localparam int        PW       = 2 * DW,
  localparam int        CW       = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_hi,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start,
  input  logic          stop,
  input  logic          sda_s,
  input  logic [DW-1:0] reg_rdata,
  output logic          sda_oe,
  output logic [PW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we
);
  localparam logic [CW-1:0] BITS = CW'(DW);

  i2ct_state_e   st;
  i2ct_kind_e    kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx;
  logic [PW-1:0] ptr;
  logic          we_q;
  logic [DW-1:0] wd_q;
  logic          mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      kind <= K_ADDR;
      cnt  <= '0;
      sh   <= '0;
      tx   <= '1;
      ptr  <= '0;
      we_q <= 1'b0;
      wd_q <= '0;
      mack <= 1'b0;
    end else begin
      we_q <= 1'b0;
      // pointer step follows the strobe by one cycle
      if (we_q) ptr <= ptr + 1'b1;
      if (stop) begin
        st <= ST_IDLE;
      end else if (start) begin
        st   <= ST_RX;
        kind <= K_ADDR;
        cnt  <= '0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS) begin
              cnt <= '0;
              unique case (kind)
                K_ADDR: begin
                  if (sh[DW-1:1] == DEV_ADDR) begin
                    st <= ST_RX_ACK;
                    if (!sh[0]) kind <= K_PTR_HI;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                K_PTR_HI: begin
                  ptr[PW-1:DW] <= sh;
                  kind         <= K_PTR_LO;
                  st           <= ST_RX_ACK;
                end
                K_PTR_LO: begin
                  ptr[DW-1:0] <= sh;
                  kind        <= K_DATA;
                  st          <= ST_RX_ACK;
                end
                K_DATA: begin
                  we_q <= 1'b1;
                  wd_q <= sh;
                  st   <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_ADDR) begin
                st <= ST_TX;
                tx <= reg_rdata;
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == BITS) begin
                st  <= ST_TX_ACK;
                cnt <= '0;
                ptr <= ptr + 1'b1;
                tx  <= '1;
              end else if (cnt != '0) begin
                tx <= {tx[DW-2:0], 1'b1};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st <= ST_TX;
                tx <= reg_rdata;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = (st == ST_RX_ACK) | ((st == ST_TX) & ~tx[DW-1]);
  assign reg_addr  = ptr;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi) && !$past(start) && !$past(stop)) |-> $stable(sda_oe)); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe); // R4
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> !sda_oe); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + 1'b1)); // R7
endmodule

// File: rtl/i2ct_target.sv
`timescale 1ns/1ps
module i2ct_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h61,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] pins_s;
  logic scl_hi, scl_rise, scl_fall, start, stop;

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (pins_s)
  );

  i2ct_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (pins_s[1]),
    .sda_s    (pins_s[0]),
    .scl_hi   (scl_hi),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start    (start),
    .stop     (stop)
  );

  i2ct_fsm #(.DEV_ADDR(DEV_ADDR), .DW(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start     (start),
    .stop      (stop),
    .sda_s     (pins_s[0]),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );
endmodule

// File: tb/i2ct_target_test.sv
`timescale 1ns/1ps
module i2ct_target_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        reg_we;
  wire         sda_bus = m_sda & ~sda_oe;

  logic [7:0]  mem [0:255];
  logic [15:0] wlog_a [0:31];
  logic [7:0]  wlog_d [0:31];
  int          wcnt = 0;
  int          viol = 0;
  logic        oe_prev = 1'b0;

  assign reg_rdata = mem[reg_addr[7:0]];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      if (wcnt < 32) begin
        wlog_a[wcnt] <= reg_addr;
        wlog_d[wcnt] <= reg_wdata;
      end
      wcnt <= wcnt + 1;
    end
    if (sda_oe != oe_prev && m_scl) viol <= viol + 1;
    oe_prev <= sda_oe;
  end

  i2ct_target uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  int total = 0;
  int bad   = 0;
  int qp    = 256;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic c_start;
    m_sda = 1'b1; #(qp);
    m_scl = 1'b1; #(qp);
    m_sda = 1'b0; #(qp);
    m_scl = 1'b0; #(qp);
  endtask

  task automatic c_stop;
    m_sda = 1'b0; #(qp);
    m_scl = 1'b1; #(qp);
    m_sda = 1'b1; #(qp);
  endtask

  task automatic c_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; #(qp);
      m_scl = 1'b1; #(2 * qp);
      m_scl = 1'b0; #(qp);
    end
  endtask

  task automatic c_wbyte(input logic [7:0] b, output logic ack);
    c_bits(b, 8);
    m_sda = 1'b1; #(qp);
    m_scl = 1'b1; #(qp);
    ack = ~sda_bus; #(qp);
    m_scl = 1'b0; #(qp);
  endtask

  task automatic c_rbyte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; #(qp);
      m_scl = 1'b1; #(qp);
      b[i] = sda_bus; #(qp);
      m_scl = 1'b0; #(qp);
    end
    m_sda = ~give_ack; #(qp);
    m_scl = 1'b1; #(2 * qp);
    m_scl = 1'b0; #(qp);
    m_sda = 1'b1;
  endtask

  // {address byte, pointer, data, acknowledge expected}
  localparam logic [32:0] VEC [0:5] = '{
    {8'hC2, 16'h0010, 8'hA5, 1'b1},
    {8'hC2, 16'h1234, 8'h3C, 1'b1},
    {8'hC4, 16'h0020, 8'h77, 1'b0},
    {8'hC2, 16'hABCD, 8'h01, 1'b1},
    {8'h42, 16'h0010, 8'hFF, 1'b0},
    {8'hE2, 16'h0050, 8'h99, 1'b0}
  };

  logic       k0, k1, k2, k3, k4, k5, k6;
  logic [7:0] b0, b1, b2, b3;
  int         w0;
  logic       done = 1'b0;

  initial begin
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #2;
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 reg_addr after reset", reg_addr, 16'h0000);

    // table walk: single-register writes, matching and foreign addresses
    for (int v = 0; v < 6; v++) begin
      w0 = wcnt;
      c_start;
      c_wbyte(VEC[v][32:25], k0);
      c_wbyte(VEC[v][24:17], k1);
      c_wbyte(VEC[v][16:9], k2);
      c_wbyte(VEC[v][8:1], k3);
      c_stop;
      #(qp);
      chk("R2 address ack", k0, VEC[v][0]);
      chk("R5 pointer acks", {k1, k2}, {2{VEC[v][0]}});
      chk("R6 data ack", k3, VEC[v][0]);
      if (VEC[v][0]) begin
        chk("R6 one strobe", wcnt - w0, 1);
        chk("R6 strobe address", wlog_a[w0], VEC[v][24:9]);
        chk("R6 stored byte", mem[VEC[v][16:9]], VEC[v][8:1]);
      end else begin
        chk("R2 foreign address writes nothing", wcnt - w0, 0);
      end
    end
    chk("R2 register kept after foreign write", mem[8'h10], 8'hA5);

    // burst at 400 kbit/s
    qp = 632;
    w0 = wcnt;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h40, k2);
    c_wbyte(8'hD0, k3); c_wbyte(8'hD1, k4); c_wbyte(8'hD2, k5); c_wbyte(8'hD3, k6);
    c_stop;
    #(qp);
    chk("R10 400k all acked", {k0, k1, k2, k3, k4, k5, k6}, 7'h7F);
    chk("R7 burst strobes", wcnt - w0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R7 burst address", wlog_a[w0 + i], 16'h0040 + 16'(i));
      chk("R7 burst data", wlog_d[w0 + i], 8'hD0 + 8'(i));
    end

    // pointer wrap
    qp = 256;
    w0 = wcnt;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'hFF, k1); c_wbyte(8'hFE, k2);
    c_wbyte(8'h11, k3); c_wbyte(8'h22, k4); c_wbyte(8'h33, k5);
    c_stop;
    #(qp);
    chk("R7 wrap first", wlog_a[w0], 16'hFFFE);
    chk("R7 wrap second", wlog_a[w0 + 1], 16'hFFFF);
    chk("R7 wrap to zero", wlog_a[w0 + 2], 16'h0000);
    chk("R7 wrap data", mem[8'h00], 8'h33);

    // read with repeated start
    w0 = wcnt;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h40, k2);
    c_start;
    c_wbyte(8'hC3, k3);
    c_rbyte(b0, 1'b1); c_rbyte(b1, 1'b1); c_rbyte(b2, 1'b0);
    c_rbyte(b3, 1'b0);
    c_stop;
    #(qp);
    chk("R2 read address ack", k3, 1);
    chk("R8 read byte 0", b0, 8'hD0);
    chk("R8 read byte 1", b1, 8'hD1);
    chk("R8 read byte 2", b2, 8'hD2);
    chk("R8 released after nack", b3, 8'hFF);
    chk("R8 read writes nothing", wcnt - w0, 0);

    // fresh read continues at stepped pointer
    c_start;
    c_wbyte(8'hC3, k0);
    c_rbyte(b0, 1'b0);
    c_stop;
    #(qp);
    chk("R9 direct read ack", k0, 1);
    chk("R9 direct read at pointer", b0, 8'hD3);

    // STOP in the middle of a byte
    w0 = wcnt;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h60, k2); c_wbyte(8'h5A, k3);
    c_bits(8'h11, 4);
    c_stop;
    #(qp);
    chk("R4 one write before stop", wcnt - w0, 1);
    chk("R4 kept byte", mem[8'h60], 8'h5A);
    chk("R4 partial byte dropped", mem[8'h61], 8'h61 ^ 8'h5A);

    // START in the middle of a byte restarts framing
    w0 = wcnt;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h62, k2);
    c_bits(8'hF0, 3);
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h62, k2); c_wbyte(8'h77, k3);
    c_stop;
    #(qp);
    chk("R4 address ack after restart", k0, 1);
    chk("R4 write after restart", mem[8'h62], 8'h77);
    chk("R4 single strobe after restart", wcnt - w0, 1);

    // 100 kbit/s
    qp = 2504;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h70, k2); c_wbyte(8'hC7, k3);
    c_stop;
    #(qp);
    chk("R10 100k acks", {k0, k1, k2, k3}, 4'hF);
    chk("R10 100k stored", mem[8'h70], 8'hC7);

    // strobe and acknowledge in one cycle, then read at stepped pointer
    qp = 256;
    w0 = wcnt;
    c_start;
    c_wbyte(8'hC2, k0); c_wbyte(8'h00, k1); c_wbyte(8'h80, k2); c_wbyte(8'hE1, k3);
    c_start;
    c_wbyte(8'hC3, k4);
    c_rbyte(b0, 1'b0);
    c_stop;
    #(qp);
    chk("R6 ack with strobe", k3, 1);
    chk("R6 strobe address old pointer", wlog_a[w0], 16'h0080);
    chk("R9 read after write uses stepped pointer", b0, 8'h81 ^ 8'h5A);

    chk("R3 sda drive changed with SCL high", viol, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule